// File: doc/BRIEF.md
# Two-Tier I/O Address Decoder

This block sits between a CPU's memory port and the peripherals in its I/O region. When the CPU raises a request aimed at that region, the block looks at two address fields and asserts exactly one per-device select strobe. The upper field picks one of the extended-device slots. Its all-ones value does not name a device of its own. Instead it opens a second tier, where a lower field picks one of the ordinary-device slots. The strobes are combinational, and all of them stay low when no request is present.

The same fields steer a 32-bit read-data multiplexer across every device. A slot with no device behind it, at either tier, reads back as all ones. Each device has an active-low wait. The block ANDs these into one CPU stall signal, which acts as the ready of the access: the CPU holds the request and address stable while `cpu_wait_n` is low, and the access completes in the first cycle that it is high. Devices that never stall tie their wait input to 1.

The block also packs system interrupt lines and per-device interrupt lines into a 32-bit interrupt vector. It provides two constant masks with that vector: one flags the edge-type lines, and one flags the indices that have no source. Device n of a tier responds at base address ((n | ~0 << field_bits) << field_shift) truncated to 32 bits, so the devices sit at the top of the address space. Field widths, shifts, device counts and interrupt counts are all parameters.

Top module: `io_region_decoder`

## Requirements
- R1: With `req_valid` high and the upper field addr[XSHIFT+XBITS-1:XSHIFT] equal to k < NX, `x_valid` is one-hot with bit k set, and `i_valid` is zero.
- R2: With `req_valid` low, every bit of `x_valid` and `i_valid` is 0, whatever the address.
- R3: Ordinary strobes need `req_valid` high and an all-ones upper field. In that case the lower field addr[ISHIFT+IBITS-1:ISHIFT] equal to j < NI gives an `i_valid` that is one-hot with bit j set, and `x_valid` is zero.
- R4: `rdata` equals word k of `x_rdata` (bits 32k+31..32k) when the upper field is k < NX. It equals word j of `i_rdata` when the upper field is all ones and the lower field is j < NI. `rdata` does not depend on `req_valid`.
- R5: `rdata` is 32'hFFFFFFFF for any other upper-field value, and for any lower-field value of NI or more. In both cases no strobe is asserted.
- R6: `cpu_wait_n` is 1 only when every bit of `x_wait_n` and `i_wait_n` is 1. A single low bit at either tier drives it to 0.
- R7: In `irq_vec`, bits NSYS-1..0 carry `sys_irq_in`, bits NSYS+NDIRQ-1..NSYS carry `dev_irq` in order, and every higher bit is 0.
- R8: `irq_edge_mask` holds SYS_EDGE at bits NSYS-1..0, DEV_EDGE at the next NDIRQ bits, and 0 above them. `irq_unused_mask` is 1 exactly at the indices NSYS+NDIRQ and above. With the defaults these are 32'h00000128 and 32'hFFFFFE00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | CPU access aimed at the I/O region |
| addr | input | 32 | CPU address |
| x_valid | output | NX | Extended-device select strobes |
| i_valid | output | NI | Ordinary-device select strobes |
| x_rdata | input | 32*NX | Read words of the extended devices, device 0 in the low word |
| i_rdata | input | 32*NI | Read words of the ordinary devices, device 0 in the low word |
| rdata | output | 32 | Selected read word |
| x_wait_n | input | NX | Active-low wait from each extended device |
| i_wait_n | input | NI | Active-low wait from each ordinary device |
| cpu_wait_n | output | 1 | Combined active-low stall (access ready) |
| sys_irq_in | input | NSYS | System interrupt lines |
| dev_irq | input | NDIRQ | Device interrupt lines in device and line order |
| irq_vec | output | 32 | Packed interrupt vector |
| irq_edge_mask | output | 32 | 1 for each edge-type interrupt index |
| irq_unused_mask | output | 32 | 1 for each index with no source |

## Verification
The bench targets the seam between the tiers. Two designs are likely to fail there: one that lets the lower field select an ordinary device under a non-top upper field would raise an `i_valid` strobe on an extended access, and one that treats the top slot as a device would return a device word where all ones is due. The bench reads unassigned slots at both tiers and expects all ones, which catches a mux that returns zero or wraps onto a real device. It drops the request with a device address held, which catches strobes that ignore `req_valid`. Walking single low wait bits and single high interrupt bits catches a stall that sees only one tier, and a vector or mask that is shifted by one.

// File: rtl/io_region_decoder_pkg.sv
package io_region_decoder_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] EMPTY_WORD = '1;
endpackage

// File: rtl/iodec_slot_decode.sv
module iodec_slot_decode #(
  parameter int unsigned XBITS  = 2,
  parameter int unsigned XSHIFT = 20,
  parameter int unsigned IBITS  = 3,
  parameter int unsigned ISHIFT = 12,
  parameter int unsigned NX     = 2,
  parameter int unsigned NI     = 5
) (
  input  logic          req_valid,
  input  logic [31:0]   addr,
  output logic [NX-1:0] x_valid,
  output logic [NI-1:0] i_valid
);
  localparam int unsigned XW = 2 ** XBITS;
  localparam int unsigned IW = 2 ** IBITS;

  logic [XBITS-1:0] xfield;
  logic [IBITS-1:0] ifield;
  logic [XW-1:0]    xvec;
  logic [IW-1:0]    ivec;

  assign xfield = addr[XSHIFT+XBITS-1:XSHIFT];
  assign ifield = addr[ISHIFT+IBITS-1:ISHIFT];

  // tier one: request bit steered by the upper field
  assign xvec = {{(XW-1){1'b0}}, req_valid} << xfield;
  // tier two: only the all-ones upper slot feeds the lower decode
  assign ivec = {{(IW-1){1'b0}}, xvec[XW-1]} << ifield;

  assign x_valid = xvec[NX-1:0];
  assign i_valid = ivec[NI-1:0];
endmodule

// File: rtl/iodec_rdata_mux.sv
module iodec_rdata_mux
  import io_region_decoder_pkg::*;
#(
  parameter int unsigned XBITS  = 2,
  parameter int unsigned XSHIFT = 20,
  parameter int unsigned IBITS  = 3,
  parameter int unsigned ISHIFT = 12,
  parameter int unsigned NX     = 2,
  parameter int unsigned NI     = 5
) (
  input  logic [31:0]        addr,
  input  logic [WORD_W*NX-1:0] x_rdata,
  input  logic [WORD_W*NI-1:0] i_rdata,
  output logic [WORD_W-1:0]  rdata
);
  localparam logic [XBITS-1:0] XTOP = '1;

  logic [XBITS-1:0] xfield;
  logic [IBITS-1:0] ifield;
  logic [WORD_W-1:0] inner;

  assign xfield = addr[XSHIFT+XBITS-1:XSHIFT];
  assign ifield = addr[ISHIFT+IBITS-1:ISHIFT];

  always_comb begin
    inner = EMPTY_WORD;
    for (int j = 0; j < int'(NI); j++) begin
      if (int'(ifield) == j) inner = i_rdata[j*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    rdata = EMPTY_WORD;
    if (xfield == XTOP) begin
      rdata = inner;
    end else begin
      for (int k = 0; k < int'(NX); k++) begin
        if (int'(xfield) == k) rdata = x_rdata[k*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/iodec_irq_pack.sv
module iodec_irq_pack #(
  parameter int unsigned NSYS  = 3,
  parameter int unsigned NDIRQ = 6,
  parameter logic [NSYS-1:0]  SYS_EDGE = '0,
  parameter logic [NDIRQ-1:0] DEV_EDGE = 6'b100101
) (
  input  logic [NSYS-1:0]  sys_irq_in,
  input  logic [NDIRQ-1:0] dev_irq,
  output logic [31:0]      irq_vec,
  output logic [31:0]      irq_edge_mask,
  output logic [31:0]      irq_unused_mask
);
  localparam int unsigned NUSED = NSYS + NDIRQ;

  always_comb begin
    irq_vec = '0;
    irq_vec[NSYS-1:0] = sys_irq_in;
    irq_vec[NSYS +: NDIRQ] = dev_irq;
  end

  always_comb begin
    irq_edge_mask = '0;
    irq_edge_mask[NSYS-1:0] = SYS_EDGE;
    irq_edge_mask[NSYS +: NDIRQ] = DEV_EDGE;
  end

  always_comb begin
    irq_unused_mask = '1;
    for (int b = 0; b < int'(NUSED); b++) irq_unused_mask[b] = 1'b0;
  end
endmodule

// File: rtl/io_region_decoder.sv
module io_region_decoder #(
  parameter int unsigned XBITS  = 2,
  parameter int unsigned XSHIFT = 20,
  parameter int unsigned IBITS  = 3,
  parameter int unsigned ISHIFT = 12,
  parameter int unsigned NX     = 2,
  parameter int unsigned NI     = 5,
  parameter int unsigned NSYS   = 3,
  parameter int unsigned NDIRQ  = 6,
  parameter logic [NSYS-1:0]  SYS_EDGE = '0,
  parameter logic [NDIRQ-1:0] DEV_EDGE = 6'b100101
) (
  input  logic              req_valid,
  input  logic [31:0]       addr,
  output logic [NX-1:0]     x_valid,
  output logic [NI-1:0]     i_valid,
  input  logic [32*NX-1:0]  x_rdata,
  input  logic [32*NI-1:0]  i_rdata,
  output logic [31:0]       rdata,
  input  logic [NX-1:0]     x_wait_n,
  input  logic [NI-1:0]     i_wait_n,
  output logic              cpu_wait_n,
  input  logic [NSYS-1:0]   sys_irq_in,
  input  logic [NDIRQ-1:0]  dev_irq,
  output logic [31:0]       irq_vec,
  output logic [31:0]       irq_edge_mask,
  output logic [31:0]       irq_unused_mask
);
  // fit checks: top upper slot is reserved for the second tier
  if (NX > 2 ** XBITS - 1) begin : g_bad_nx
    $fatal(1, "too many extended devices for the upper field");
  end
  if (NI > 2 ** IBITS) begin : g_bad_ni
    $fatal(1, "too many ordinary devices for the lower field");
  end
  if (NSYS + NDIRQ > 32) begin : g_bad_irq
    $fatal(1, "interrupt sources exceed the 32-bit vector");
  end

  iodec_slot_decode #(
    .XBITS(XBITS), .XSHIFT(XSHIFT), .IBITS(IBITS), .ISHIFT(ISHIFT),
    .NX(NX), .NI(NI)
  ) u_decode (
    .req_valid(req_valid), .addr(addr),
    .x_valid(x_valid), .i_valid(i_valid)
  );

  iodec_rdata_mux #(
    .XBITS(XBITS), .XSHIFT(XSHIFT), .IBITS(IBITS), .ISHIFT(ISHIFT),
    .NX(NX), .NI(NI)
  ) u_mux (
    .addr(addr), .x_rdata(x_rdata), .i_rdata(i_rdata), .rdata(rdata)
  );

  iodec_irq_pack #(
    .NSYS(NSYS), .NDIRQ(NDIRQ), .SYS_EDGE(SYS_EDGE), .DEV_EDGE(DEV_EDGE)
  ) u_irq (
    .sys_irq_in(sys_irq_in), .dev_irq(dev_irq), .irq_vec(irq_vec),
    .irq_edge_mask(irq_edge_mask), .irq_unused_mask(irq_unused_mask)
  );

  assign cpu_wait_n = (&x_wait_n) & (&i_wait_n);
endmodule

// File: rtl/io_region_decoder_chk.sv
module io_region_decoder_chk #(
  parameter int unsigned XBITS  = 2,
  parameter int unsigned XSHIFT = 20,
  parameter int unsigned IBITS  = 3,
  parameter int unsigned ISHIFT = 12,
  parameter int unsigned NX     = 2,
  parameter int unsigned NI     = 5
) (
  input logic          req_valid,
  input logic [31:0]   addr,
  input logic [NX-1:0] x_valid,
  input logic [NI-1:0] i_valid,
  input logic [31:0]   rdata,
  input logic [NX-1:0] x_wait_n,
  input logic [NI-1:0] i_wait_n,
  input logic          cpu_wait_n,
  input logic [31:0]   irq_vec,
  input logic [31:0]   irq_unused_mask
);
  logic [XBITS-1:0] xf;
  assign xf = addr[XSHIFT+XBITS-1:XSHIFT];

  always_comb begin
    a_r1_onehot_strobes: assert ($onehot0({x_valid, i_valid}));
    a_r2_idle_no_strobe: assert (req_valid || ({x_valid, i_valid} == '0));
    a_r3_inner_needs_top: assert ((i_valid == '0) || (&xf));
    a_r5_empty_ones: assert ((&xf) || (int'(xf) < int'(NX)) || (rdata == '1));
    a_r6_stall_source: assert (cpu_wait_n || !(&{x_wait_n, i_wait_n}));
    a_r7_unused_quiet: assert ((irq_vec & irq_unused_mask) == '0);
  end
endmodule

bind io_region_decoder io_region_decoder_chk #(
  .XBITS(XBITS), .XSHIFT(XSHIFT), .IBITS(IBITS), .ISHIFT(ISHIFT),
  .NX(NX), .NI(NI)
) u_chk (
  .req_valid(req_valid), .addr(addr), .x_valid(x_valid), .i_valid(i_valid),
  .rdata(rdata), .x_wait_n(x_wait_n), .i_wait_n(i_wait_n),
  .cpu_wait_n(cpu_wait_n), .irq_vec(irq_vec),
  .irq_unused_mask(irq_unused_mask)
);

// File: tb/test_io_region_decoder.sv
module test_io_region_decoder;
  localparam int XBITS = 2, XSHIFT = 20, IBITS = 3, ISHIFT = 12;
  localparam int NX = 2, NI = 5, NSYS = 3, NDIRQ = 6;
  localparam logic [NDIRQ-1:0] DEDGE = 6'b100101;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic [31:0]       addr = '0;
  logic [NX-1:0]     x_valid;
  logic [NI-1:0]     i_valid;
  logic [32*NX-1:0]  x_rdata;
  logic [32*NI-1:0]  i_rdata;
  logic [31:0]       rdata;
  logic [NX-1:0]     x_wait_n = '1;
  logic [NI-1:0]     i_wait_n = '1;
  logic              cpu_wait_n;
  logic [NSYS-1:0]   sys_irq_in = '0;
  logic [NDIRQ-1:0]  dev_irq = '0;
  logic [31:0]       irq_vec, irq_edge_mask, irq_unused_mask;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  io_region_decoder i_io_region_decoder (
    .req_valid(req_valid), .addr(addr), .x_valid(x_valid), .i_valid(i_valid),
    .x_rdata(x_rdata), .i_rdata(i_rdata), .rdata(rdata),
    .x_wait_n(x_wait_n), .i_wait_n(i_wait_n), .cpu_wait_n(cpu_wait_n),
    .sys_irq_in(sys_irq_in), .dev_irq(dev_irq), .irq_vec(irq_vec),
    .irq_edge_mask(irq_edge_mask), .irq_unused_mask(irq_unused_mask)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // address of slot (xf, inner) with all-ones filler above the fields
  function automatic logic [31:0] mk_addr(int xf, int inf, logic [11:0] low);
    logic [31:0] a;
    a = 32'hFFFF_FFFF;
    a[XSHIFT+XBITS-1:XSHIFT] = XBITS'(xf);
    a[ISHIFT+IBITS-1:ISHIFT] = IBITS'(inf);
    a[11:0] = low;
    return a;
  endfunction

  task automatic apply(logic rv, logic [31:0] a);
    @(negedge clk);
    req_valid = rv;
    addr = a;
    #2;
  endtask

  task automatic t_reset_state();
    apply(1'b0, 32'h0);
    check("R2 idle x_valid", 32'(x_valid), 32'h0);
    check("R2 idle i_valid", 32'(i_valid), 32'h0);
    check("R6 idle wait", 32'(cpu_wait_n), 32'h1);
  endtask

  task automatic t_ext_slots();
    for (int k = 0; k < NX; k++) begin
      apply(1'b1, mk_addr(k, 3, 12'h5A4));
      check("R1 x_valid", 32'(x_valid), 32'(1) << k);
      check("R1 i_valid quiet", 32'(i_valid), 32'h0);
      check("R4 ext rdata", rdata, 32'hA000_0000 + 32'(k));
    end
  endtask

  task automatic t_inner_slots();
    for (int j = 0; j < NI; j++) begin
      apply(1'b1, mk_addr(3, j, 12'h01C));
      check("R3 i_valid", 32'(i_valid), 32'(1) << j);
      check("R3 x_valid quiet", 32'(x_valid), 32'h0);
      check("R4 inner rdata", rdata, 32'hB000_0000 + 32'(j));
    end
  endtask

  task automatic t_empty_slots();
    apply(1'b1, mk_addr(2, 0, 12'h000));
    check("R5 empty upper rdata", rdata, 32'hFFFF_FFFF);
    check("R5 empty upper strobes", 32'({x_valid, i_valid}), 32'h0);
    for (int j = NI; j < 8; j++) begin
      apply(1'b1, mk_addr(3, j, 12'h004));
      check("R5 empty inner rdata", rdata, 32'hFFFF_FFFF);
      check("R5 empty inner strobes", 32'({x_valid, i_valid}), 32'h0);
    end
  endtask

  task automatic t_no_request();
    apply(1'b0, mk_addr(1, 0, 12'h0));
    check("R2 no req x_valid", 32'(x_valid), 32'h0);
    check("R4 rdata without req", rdata, 32'hA000_0001);
    apply(1'b0, mk_addr(3, 2, 12'h0));
    check("R2 no req i_valid", 32'(i_valid), 32'h0);
    check("R4 inner rdata without req", rdata, 32'hB000_0002);
  endtask

  task automatic t_wait();
    for (int b = 0; b < NX + NI; b++) begin
      @(negedge clk);
      x_wait_n = '1; i_wait_n = '1;
      if (b < NX) x_wait_n[b] = 1'b0; else i_wait_n[b-NX] = 1'b0;
      #2;
      check("R6 single waiter", 32'(cpu_wait_n), 32'h0);
    end
    @(negedge clk);
    x_wait_n = '1; i_wait_n = '1;
    #2;
    check("R6 none waiting", 32'(cpu_wait_n), 32'h1);
  endtask

  task automatic t_irq();
    check("R8 edge mask", irq_edge_mask, 32'(DEDGE) << NSYS);
    check("R8 unused mask", irq_unused_mask, ~((32'(1) << (NSYS + NDIRQ)) - 1));
    for (int b = 0; b < NSYS + NDIRQ; b++) begin
      @(negedge clk);
      sys_irq_in = '0; dev_irq = '0;
      if (b < NSYS) sys_irq_in[b] = 1'b1; else dev_irq[b-NSYS] = 1'b1;
      #2;
      check("R7 irq position", irq_vec, 32'(1) << b);
    end
    @(negedge clk);
    sys_irq_in = '1; dev_irq = '1;
    #2;
    check("R7 all lines", irq_vec, 32'h0000_01FF);
  endtask

  initial begin
    for (int k = 0; k < NX; k++) x_rdata[k*32 +: 32] = 32'hA000_0000 + 32'(k);
    for (int j = 0; j < NI; j++) i_rdata[j*32 +: 32] = 32'hB000_0000 + 32'(j);
    t_reset_state();
    t_ext_slots();
    t_inner_slots();
    t_empty_slots();
    t_no_request();
    t_wait();
    t_irq();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule